// File: doc/BRIEF.md
# SDRAM Write Burst Sequencer

This block is the write side of an SDRAM controller, placed after row activation and bank arbitration. A request gives a bank, a starting column, a word count of 1 to `BL` and an end mode. The block issues the WRITE command and drives the data words and byte masks on the SDRAM pins. It closes the burst in one of three ways: with auto precharge, with an explicit PRECHARGE after the write recovery time, or with a BURST TERMINATE. The SDRAM mode register is assumed to hold a fixed burst length `BL`.

Write data is pulled from the source one word per clock. The block raises `dat_rdy` on each edge that consumes a word. Every word carries a keep flag, and a word with the flag low is sent with all DQM lanes high so the device does not store it. A per-bank recovery counter blocks new requests to a bank that is still recovering from a precharge. Requests to other banks go ahead as soon as the sequencer itself is free. Recovery times are parameters counted in clocks: `TWR` for write recovery and `TRP` for precharge recovery.

Top module: `sdram_wr_seq`

## Requirements
- R1: When a request is accepted (`req_valid` and `req_ready` at an edge), that edge registers a WRITE (cs_n,ras_n,cas_n,we_n = 0,1,0,0) with `sd_ba` = bank, `sd_addr[COL_W-1:0]` = column, `sd_addr[AP_BIT]` = 1 only for mode 0, all other address bits 0, `sd_dq_oe` = 1 and the first data word on `sd_dq_out`.
- R2: Words 2 to N of the request are driven on the following N-1 edges, one per edge, with a NOP command (0,1,1,1) and `sd_dq_oe` = 1. For every word, DQM is all zeros when `dat_keep` is 1 and all ones when it is 0.
- R3: Mode 0 (auto precharge): after the last requested word, the remaining BL-N positions of the burst are driven with `sd_dq_oe` = 1, data 0 and DQM all ones. No PRECHARGE or BURST TERMINATE is issued.
- R4: Mode 1 (explicit precharge): a PRECHARGE (0,0,1,0) to the same bank, with all address bits 0, is registered exactly max(TWR,2) edges after the edge of the last requested word. The edges in between carry NOPs with no data drive.
- R5: In mode 1, DQM is all ones on the edge before the PRECHARGE and on the PRECHARGE edge itself.
- R6: Modes 2 and 3 (terminate): a BURST TERMINATE (0,1,1,0) with DQM all ones and no data drive is registered one edge after the last requested word, unless R7 applies.
- R7: A request accepted in the terminate slot takes the place of the BURST TERMINATE. This allows WRITE commands on consecutive edges, to the same bank or to a different bank.
- R8: `req_ready` is 1 only when the sequencer is idle or in the terminate slot and the bank on `req_bank` has finished recovering. After a mode 0 WRITE, the bank recovers BL+TWR+TRP edges after that WRITE. After a PRECHARGE, it recovers TRP edges after the PRECHARGE.
- R9: A bank still recovering does not block requests to other banks once the sequencer is idle.
- R10: No PRECHARGE is ever issued to a bank whose latest WRITE used auto precharge.
- R11: During and after reset, and whenever no command is due, the pins show NOP, bank 0, address 0, data 0, `sd_dq_oe` 0 and DQM all ones.
- R12: `dat_rdy` is 1 exactly in the cycles whose following edge registers a data word (the WRITE edge and each R2 edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request may be accepted this cycle |
| req_bank | input | BA_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Word count, 1..BL |
| req_mode | input | 2 | End mode: 0 auto precharge, 1 precharge, 2/3 terminate |
| dat_word | input | DQ_W | Current write word |
| dat_keep | input | 1 | Current word is to be stored |
| dat_rdy | output | 1 | Current word is consumed at this edge |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dq_out | output | DQ_W | Data to the device |
| sd_dq_oe | output | 1 | Data drive enable |
| sd_dqm | output | DQ_W/8 | Byte masks, high = not written |

## Verification
A wrong burst position or word count shows up at once. The NOP after a word comes out unmasked, or the closing command lands on a different edge from the one the word count predicts. A recovery counter that is loaded wrongly, or that decrements wrongly, stays hidden until a later request names that bank. It then appears as `req_ready` rising too early or too late, and a WRITE that is too early breaks the per-bank gap. A wrong end-mode state shows in the first cycle after the last wanted word, as a missing mask, a wrong command, or a PRECHARGE following an auto-precharge burst.

// File: rtl/wsq_pkg.sv
`timescale 1ns/1ps
package wsq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_PAD,
      ST_WAIT,
      ST_TERM
   } wsq_state_e;

   typedef enum logic [1:0] {
      END_AUTO = 2'd0,
      END_PRE  = 2'd1,
      END_TERM = 2'd2
   } wsq_end_e;

   typedef enum logic [1:0] {
      OP_NOP,
      OP_WRITE,
      OP_PRE,
      OP_BST
   } wsq_op_e;

   // {cs_n, ras_n, cas_n, we_n}
   function automatic logic [3:0] op_pins(input wsq_op_e op);
      case (op)
         OP_WRITE: op_pins = 4'b0100;
         OP_PRE:   op_pins = 4'b0010;
         OP_BST:   op_pins = 4'b0110;
         default:  op_pins = 4'b0111;
      endcase
   endfunction

   function automatic wsq_end_e decode_end(input logic [1:0] code);
      case (code)
         2'd0:    decode_end = END_AUTO;
         2'd1:    decode_end = END_PRE;
         default: decode_end = END_TERM;
      endcase
   endfunction

endpackage

// File: rtl/wsq_bank_timer.sv
`timescale 1ns/1ps
module wsq_bank_timer #(
   parameter int BANKS = 4,
   parameter int CW    = 4,
   localparam int BA_W = $clog2(BANKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BA_W-1:0]  load_bank,
   input  logic [CW-1:0]    load_val,
   output logic [BANKS-1:0] bank_free
);

   for (genvar i = 0; i < BANKS; i++) begin : g_bank
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (load && (load_bank == BA_W'(i))) begin
            cnt <= load_val;
         end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
         end
      end

      assign bank_free[i] = (cnt == '0);
   end

endmodule

// File: rtl/wsq_ctrl.sv
`timescale 1ns/1ps
module wsq_ctrl
   import wsq_pkg::*;
#(
   parameter int BANKS = 4,
   parameter int COL_W = 8,
   parameter int BL    = 8,
   parameter int TWR   = 2,
   parameter int TRP   = 3,
   localparam int BA_W  = $clog2(BANKS),
   localparam int LEN_W = $clog2(BL + 1),
   localparam int GAP   = (TWR > 2) ? TWR : 2,
   localparam int WCW   = $clog2(((BL > GAP) ? BL : GAP) + 1),
   localparam int CW    = $clog2(BL + TWR + TRP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [BA_W-1:0]  req_bank,
   input  logic [COL_W-1:0] req_col,
   input  logic [LEN_W-1:0] req_len,
   input  logic [1:0]       req_mode,
   input  logic [BANKS-1:0] bank_free,
   output wsq_op_e          op,
   output logic [BA_W-1:0]  op_bank,
   output logic [COL_W-1:0] op_col,
   output logic             op_ap,
   output logic             drive,
   output logic             take,
   output logic             ld,
   output logic [BA_W-1:0]  ld_bank,
   output logic [CW-1:0]    ld_val
);

   localparam logic [LEN_W-1:0] BL_L   = LEN_W'(BL);
   localparam logic [LEN_W-1:0] ONE_L  = LEN_W'(1);
   localparam logic [WCW-1:0]   BL_W   = WCW'(BL);
   localparam logic [WCW-1:0]   GAP_M1 = WCW'(GAP - 1);
   localparam logic [CW-1:0]    AUTO_V = CW'(BL + TWR + TRP);
   localparam logic [CW-1:0]    PRE_V  = CW'(TRP);

   wsq_state_e       st, st_n;
   logic [LEN_W-1:0] pos, pos_n, len_r, len_n, fin_len;
   wsq_end_e         md_r, md_n, fin_md, req_md;
   logic [BA_W-1:0]  bk_r, bk_n;
   logic [WCW-1:0]   wc, wc_n;
   logic             accept, fin;

   assign req_md    = decode_end(req_mode);
   assign req_ready = ((st == ST_IDLE) || (st == ST_TERM)) && bank_free[req_bank];
   assign accept    = req_valid && req_ready;

   always_comb begin
      st_n    = st;
      pos_n   = pos;
      len_n   = len_r;
      md_n    = md_r;
      bk_n    = bk_r;
      wc_n    = wc;
      op      = OP_NOP;
      op_bank = bk_r;
      op_col  = '0;
      op_ap   = 1'b0;
      drive   = 1'b0;
      take    = 1'b0;
      ld      = 1'b0;
      ld_bank = bk_r;
      ld_val  = '0;
      fin     = 1'b0;
      fin_len = len_r;
      fin_md  = md_r;

      case (st)
         ST_IDLE, ST_TERM: begin
            if (st == ST_TERM) op = OP_BST;
            st_n = ST_IDLE;
            if (accept) begin
               op      = OP_WRITE;
               op_bank = req_bank;
               op_col  = req_col;
               op_ap   = (req_md == END_AUTO);
               drive   = 1'b1;
               take    = 1'b1;
               bk_n    = req_bank;
               len_n   = req_len;
               md_n    = req_md;
               pos_n   = ONE_L;
               if (req_md == END_AUTO) begin
                  ld      = 1'b1;
                  ld_bank = req_bank;
                  ld_val  = AUTO_V;
               end
               if (req_len <= ONE_L) begin
                  fin     = 1'b1;
                  fin_len = req_len;
                  fin_md  = req_md;
               end else begin
                  st_n = ST_DATA;
               end
            end
         end
         ST_DATA: begin
            drive = 1'b1;
            take  = 1'b1;
            pos_n = pos + ONE_L;
            if ((pos + ONE_L) >= len_r) fin = 1'b1;
         end
         ST_PAD: begin
            drive = 1'b1;
            wc_n  = wc - 1'b1;
            if (wc <= WCW'(1)) st_n = ST_IDLE;
         end
         ST_WAIT: begin
            if (wc != '0) begin
               wc_n = wc - 1'b1;
            end else begin
               op      = OP_PRE;
               ld      = 1'b1;
               ld_bank = bk_r;
               ld_val  = PRE_V;
               st_n    = ST_IDLE;
            end
         end
         default: st_n = ST_IDLE;
      endcase

      if (fin) begin
         case (fin_md)
            END_AUTO: begin
               if (fin_len < BL_L) begin
                  st_n = ST_PAD;
                  wc_n = BL_W - WCW'(fin_len);
               end else begin
                  st_n = ST_IDLE;
               end
            end
            END_PRE: begin
               st_n = ST_WAIT;
               wc_n = GAP_M1;
            end
            default: st_n = ST_TERM;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         pos   <= '0;
         len_r <= '0;
         md_r  <= END_TERM;
         bk_r  <= '0;
         wc    <= '0;
      end else begin
         st    <= st_n;
         pos   <= pos_n;
         len_r <= len_n;
         md_r  <= md_n;
         bk_r  <= bk_n;
         wc    <= wc_n;
      end
   end

endmodule

// File: rtl/wsq_pin_reg.sv
`timescale 1ns/1ps
module wsq_pin_reg
   import wsq_pkg::*;
#(
   parameter int BANKS  = 4,
   parameter int COL_W  = 8,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10,
   parameter int DQ_W   = 16,
   localparam int BA_W  = $clog2(BANKS),
   localparam int DM_W  = DQ_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wsq_op_e           op,
   input  logic [BA_W-1:0]   op_bank,
   input  logic [COL_W-1:0]  op_col,
   input  logic              op_ap,
   input  logic              drive,
   input  logic              take,
   input  logic [DQ_W-1:0]   dat_word,
   input  logic              dat_keep,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DQ_W-1:0]   sd_dq_out,
   output logic              sd_dq_oe,
   output logic [DM_W-1:0]   sd_dqm
);

   logic [ADDR_W-1:0] addr_n;
   logic [BA_W-1:0]   ba_n;
   logic [3:0]        cmd_n;

   always_comb begin
      addr_n = '0;
      ba_n   = '0;
      cmd_n  = op_pins(op);
      if (op == OP_WRITE) begin
         addr_n[COL_W-1:0] = op_col;
         addr_n[AP_BIT]    = op_ap;
      end
      if ((op == OP_WRITE) || (op == OP_PRE)) ba_n = op_bank;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= 4'b0111;
         sd_ba     <= '0;
         sd_addr   <= '0;
         sd_dq_out <= '0;
         sd_dq_oe  <= 1'b0;
         sd_dqm    <= '1;
      end else begin
         {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd_n;
         sd_ba     <= ba_n;
         sd_addr   <= addr_n;
         sd_dq_out <= take ? dat_word : '0;
         sd_dq_oe  <= drive;
         sd_dqm    <= (take && dat_keep) ? '0 : '1;
      end
   end

endmodule

// File: rtl/sdram_wr_seq.sv
`timescale 1ns/1ps
module sdram_wr_seq
   import wsq_pkg::*;
#(
   parameter int BANKS  = 4,
   parameter int COL_W  = 8,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10,
   parameter int DQ_W   = 16,
   parameter int BL     = 8,
   parameter int TWR    = 2,
   parameter int TRP    = 3,
   localparam int BA_W  = $clog2(BANKS),
   localparam int LEN_W = $clog2(BL + 1),
   localparam int DM_W  = DQ_W / 8,
   localparam int CW    = $clog2(BL + TWR + TRP + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BA_W-1:0]   req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [1:0]        req_mode,
   input  logic [DQ_W-1:0]   dat_word,
   input  logic              dat_keep,
   output logic              dat_rdy,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DQ_W-1:0]   sd_dq_out,
   output logic              sd_dq_oe,
   output logic [DM_W-1:0]   sd_dqm
);

   if (BANKS < 2 || (1 << BA_W) != BANKS) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (BL != 1 && BL != 2 && BL != 4 && BL != 8) begin : g_bad_bl
      $error("BL must be 1, 2, 4 or 8");
   end
   if (TWR < 1 || TRP < 1) begin : g_bad_rec
      $error("TWR and TRP must be at least one clock");
   end
   if (AP_BIT < COL_W || AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie above the column field and inside the address bus");
   end
   if (DQ_W % 8 != 0 || DQ_W < 8) begin : g_bad_dq
      $error("DQ_W must be a whole number of bytes");
   end

   wsq_op_e          op;
   logic [BA_W-1:0]  op_bank, ld_bank;
   logic [COL_W-1:0] op_col;
   logic             op_ap, drive, take, ld;
   logic [CW-1:0]    ld_val;
   logic [BANKS-1:0] bank_free;

   assign dat_rdy = take;

   wsq_ctrl #(
      .BANKS(BANKS), .COL_W(COL_W), .BL(BL), .TWR(TWR), .TRP(TRP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_mode(req_mode),
      .bank_free(bank_free),
      .op(op), .op_bank(op_bank), .op_col(op_col), .op_ap(op_ap),
      .drive(drive), .take(take),
      .ld(ld), .ld_bank(ld_bank), .ld_val(ld_val)
   );

   wsq_bank_timer #(
      .BANKS(BANKS), .CW(CW)
   ) u_timer (
      .clk(clk), .rst_n(rst_n),
      .load(ld), .load_bank(ld_bank), .load_val(ld_val),
      .bank_free(bank_free)
   );

   wsq_pin_reg #(
      .BANKS(BANKS), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .DQ_W(DQ_W)
   ) u_pins (
      .clk(clk), .rst_n(rst_n),
      .op(op), .op_bank(op_bank), .op_col(op_col), .op_ap(op_ap),
      .drive(drive), .take(take),
      .dat_word(dat_word), .dat_keep(dat_keep),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
   );

endmodule

// File: rtl/sdram_wr_seq_chk.sv
`timescale 1ns/1ps
module sdram_wr_seq_chk #(
   parameter int BANKS  = 4,
   parameter int ADDR_W = 12,
   parameter int AP_BIT = 10,
   parameter int DM_W   = 2,
   parameter int BL     = 8,
   parameter int TWR    = 2,
   parameter int TRP    = 3,
   localparam int BA_W  = $clog2(BANKS),
   localparam int GW    = $clog2(BL + TWR + TRP + 1),
   localparam int SW    = $clog2(TWR + 2) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [BA_W-1:0]   sd_ba,
   input logic [ADDR_W-1:0] sd_addr,
   input logic              sd_dq_oe,
   input logic [DM_W-1:0]   sd_dqm,
   input logic              dat_rdy
);

   logic is_wr, is_pre, is_bst;
   assign is_wr  = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0100);
   assign is_pre = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010);
   assign is_bst = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0110);

   logic [BANKS-1:0]         ap_open;
   logic [BANKS-1:0][GW-1:0] gap;
   logic [SW-1:0]            since;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ap_open <= '0;
         gap     <= '0;
         since   <= SW'(TWR + 1);
      end else begin
         for (int i = 0; i < BANKS; i++) begin
            if (is_wr && sd_ba == BA_W'(i)) begin
               ap_open[i] <= sd_addr[AP_BIT];
               if (sd_addr[AP_BIT]) gap[i] <= GW'(BL + TWR + TRP - 1);
               else if (gap[i] != '0) gap[i] <= gap[i] - 1'b1;
            end else if (is_pre && sd_ba == BA_W'(i)) begin
               gap[i] <= GW'(TRP - 1);
            end else if (gap[i] != '0) begin
               gap[i] <= gap[i] - 1'b1;
            end
         end
         if (sd_dq_oe && sd_dqm == '0) since <= SW'(1);
         else if (since < SW'(TWR + 1)) since <= since + 1'b1;
      end
   end

   p_write_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> sd_dq_oe);

   p_pre_recovery_r4: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> since >= SW'(TWR));

   p_mask_around_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> ((&sd_dqm) && (&$past(sd_dqm))));

   p_term_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      is_bst |-> ((&sd_dqm) && !sd_dq_oe));

   p_bank_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> gap[sd_ba] == '0);

   p_no_pre_on_ap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> !ap_open[sd_ba]);

   p_take_drives_r12: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rdy |=> sd_dq_oe);

endmodule

bind sdram_wr_seq sdram_wr_seq_chk #(
   .BANKS(BANKS), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .DM_W(DM_W),
   .BL(BL), .TWR(TWR), .TRP(TRP)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
   .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm),
   .dat_rdy(dat_rdy)
);

// File: tb/sim_sdram_wr_seq.sv
`timescale 1ns/1ps
module sim_sdram_wr_seq;

   localparam int BANKS = 4, COL_W = 8, ADDR_W = 12, AP_BIT = 10, DQ_W = 16;
   localparam int BL = 8, TWR = 2, TRP = 3;
   localparam int BA_W = $clog2(BANKS), LEN_W = $clog2(BL + 1), DM_W = DQ_W / 8;
   localparam int GAP = (TWR > 2) ? TWR : 2;
   localparam int NCYC = 4000;

   localparam int K_W = 1, K_D = 2, K_PAD = 3, K_NM = 4, K_PRE = 5, K_BST = 6;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n, req_valid, req_ready, dat_keep, dat_rdy;
   logic [BA_W-1:0]   req_bank;
   logic [COL_W-1:0]  req_col;
   logic [LEN_W-1:0]  req_len;
   logic [1:0]        req_mode;
   logic [DQ_W-1:0]   dat_word;
   logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
   logic [BA_W-1:0]   sd_ba;
   logic [ADDR_W-1:0] sd_addr;
   logic [DQ_W-1:0]   sd_dq_out;
   logic [DM_W-1:0]   sd_dqm;

   sdram_wr_seq u0 (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_col(req_col), .req_len(req_len), .req_mode(req_mode),
      .dat_word(dat_word), .dat_keep(dat_keep), .dat_rdy(dat_rdy),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
   );

   typedef struct {
      int kind;
      int bank;
      int col;
      bit ap;
      bit repl;
   } ent_t;

   ent_t        q[$];
   int          busy[BANKS];
   bit          apm[BANKS];
   int          checks = 0, errors = 0;
   bit          done = 1'b0;
   logic [63:0] exp_v;
   string       exp_tag;

   function automatic logic [63:0] pk(input logic [3:0] cmd, input int ba, input int addr,
                                      input bit oe, input logic [DQ_W-1:0] dq,
                                      input logic [DM_W-1:0] dm);
      pk = 64'({cmd, BA_W'(ba), ADDR_W'(addr), oe, dq, dm});
   endfunction

   function automatic logic [63:0] pins_now();
      pins_now = 64'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr,
                      sd_dq_oe, sd_dq_out, sd_dqm});
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive_inputs(input int cyc);
      req_valid = (($urandom % 4) != 0);
      req_bank  = BA_W'($urandom % BANKS);
      req_col   = COL_W'($urandom);
      req_len   = (($urandom % 3) == 0) ? LEN_W'(1) : LEN_W'(1 + ($urandom % BL));
      req_mode  = 2'($urandom % 4);
      dat_word  = DQ_W'($urandom);
      dat_keep  = (($urandom % 5) != 0);
      if (cyc < 60) begin
         // back-to-back single-word writes through the terminate slot (R7)
         req_valid = 1'b1;
         req_len   = LEN_W'(1);
         req_mode  = 2'd2;
      end else if (cyc < 240) begin
         // all to bank 0 so recovery blocking is exercised (R8)
         req_valid = 1'b1;
         req_bank  = '0;
         req_mode  = 2'($urandom % 2);
      end
   endtask

   task automatic model_step();
      bit   mrdy, acc, repl, pre_pop, other_busy;
      int   m, pre_bank;
      ent_t e;
      logic [DM_W-1:0] dm_w;

      other_busy = 1'b0;
      for (int b = 0; b < BANKS; b++) if (b != int'(req_bank) && busy[b] != 0) other_busy = 1'b1;
      mrdy = ((q.size() == 0) || q[0].repl) && (busy[req_bank] == 0);
      chk(other_busy ? "R9 ready" : "R8 ready", 64'(req_ready), 64'(mrdy));

      acc  = req_valid && mrdy;
      repl = 1'b0;
      m    = (req_mode > 2) ? 2 : int'(req_mode);
      if (acc) begin
         if (q.size() > 0 && q[0].repl) begin
            void'(q.pop_front());
            repl = 1'b1;
         end
         q.push_back('{K_W, int'(req_bank), int'(req_col), (m == 0), 1'b0});
         for (int i = 1; i < int'(req_len); i++) q.push_back('{K_D, 0, 0, 1'b0, 1'b0});
         if (m == 0) begin
            for (int i = int'(req_len); i < BL; i++) q.push_back('{K_PAD, 0, 0, 1'b0, 1'b0});
         end else if (m == 1) begin
            for (int i = 1; i < GAP; i++) q.push_back('{K_NM, 0, 0, 1'b0, 1'b0});
            q.push_back('{K_PRE, int'(req_bank), 0, 1'b0, 1'b0});
         end else begin
            q.push_back('{K_BST, 0, 0, 1'b0, 1'b1});
         end
         apm[req_bank] = (m == 0);
      end

      chk("R12 dat_rdy", 64'(dat_rdy),
          64'(q.size() > 0 && (q[0].kind == K_W || q[0].kind == K_D)));

      dm_w     = dat_keep ? '0 : '1;
      pre_pop  = 1'b0;
      pre_bank = 0;
      if (q.size() == 0) begin
         exp_v   = pk(4'b0111, 0, 0, 1'b0, '0, '1);
         exp_tag = "R11 idle";
      end else begin
         e = q.pop_front();
         case (e.kind)
            K_W: begin
               exp_v   = pk(4'b0100, e.bank, e.col | (int'(e.ap) << AP_BIT), 1'b1, dat_word, dm_w);
               exp_tag = repl ? "R7 write in terminate slot" : "R1 write";
            end
            K_D: begin
               exp_v   = pk(4'b0111, 0, 0, 1'b1, dat_word, dm_w);
               exp_tag = "R2 data";
            end
            K_PAD: begin
               exp_v   = pk(4'b0111, 0, 0, 1'b1, '0, '1);
               exp_tag = "R3 pad";
            end
            K_NM: begin
               exp_v   = pk(4'b0111, 0, 0, 1'b0, '0, '1);
               exp_tag = "R5 mask before precharge";
            end
            K_PRE: begin
               exp_v    = pk(4'b0010, e.bank, 0, 1'b0, '0, '1);
               exp_tag  = "R4 precharge";
               pre_pop  = 1'b1;
               pre_bank = e.bank;
            end
            default: begin
               exp_v   = pk(4'b0110, 0, 0, 1'b0, '0, '1);
               exp_tag = "R6 terminate";
            end
         endcase
      end

      for (int b = 0; b < BANKS; b++) if (busy[b] > 0) busy[b]--;
      if (acc && m == 0) busy[req_bank] = BL + TWR + TRP;
      if (pre_pop) busy[pre_bank] = TRP;
   endtask

   initial begin
      for (int b = 0; b < BANKS; b++) begin
         busy[b] = 0;
         apm[b]  = 1'b0;
      end
      rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_col = '0; req_len = LEN_W'(1);
      req_mode = '0; dat_word = '0; dat_keep = 1'b0;
      exp_v   = pk(4'b0111, 0, 0, 1'b0, '0, '1);
      exp_tag = "R11 idle";
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (i > 0) chk("R11 reset pins", pins_now(), exp_v);
      end
      chk("R11 reset ready", 64'(req_ready), 64'(1));
      rst_n = 1'b1;
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         chk(exp_tag, pins_now(), exp_v);
         if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0010)
            chk("R10 precharge after auto", 64'(apm[sd_ba]), 64'(0));
         drive_inputs(cyc);
         #1;
         model_step();
         @(negedge clk);
      end
      chk(exp_tag, pins_now(), exp_v);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (NCYC + 2000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule